// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Registers

This block holds the two 16-bit slot registers of a downstream or root port with native hot-plug: a control register for event enables, indicators, power and the interlock, and a status register for the latched slot events, the presence state and the interlock state. Software writes and reads them through a plain configuration port, one register per access, selected by a one-bit register select.

The block takes a presence level that is sampled at reset, an attention-button pulse, a device-attached pulse and an unplug-request pulse. It drives the slot power enable, both indicator fields, the interlock state, the link-active flag, and pulses that report a completed unplug or a refused unplug request. It signals hot-plug events either as a level interrupt or, when message interrupts are enabled, as a one-cycle pulse each time the combined notify condition changes.

Top module: `hp_slot_ctrl`

## Requirements
- R1: The notify condition is true when control bit 5 (hot-plug interrupt enable) is 1 and, for at least one event bit k in 0..4, status bit k and control bit k are both 1. With `msi_en_i` low, `intx_o` equals the notify condition one cycle after the update that changed it.
- R2: With `msi_en_i` high, `msi_pulse_o` is high for exactly one cycle after each change of the notify condition, rising or falling, and `intx_o` stays low.
- R3: Raising an event whose status bit is already 1 changes nothing and gives no new `msi_pulse_o`.
- R4: Status bits 0..4 (button, power fault, sensor change, presence change, command done) clear when written with 1 and stay unchanged when written with 0.
- R5: If a status write carries a 1 for any event bit that was 0 before the write, the whole clear is cancelled and all event bits keep their values.
- R6: A control write with bit 11 set toggles the interlock state (status bit 7, `interlock_o`); control bit 11 reads 0.
- R7: Every control write sets status bit 4 (command done), after all other effects of that write.
- R8: With the device present (status bit 6), a control write that sets bit 10 (power off) with bits 9:8 = 2'b11 (indicator off), when power-off with indicator-off was not both in force before, performs an unplug: status bit 6 and `link_up_o` clear, status bit 3 sets, `unplug_o` pulses one cycle.
- R9: On reset, control bits 0..5 and 11 are 0 and bits 7:6 = 2'b11 (attention off); status event bits and bit 7 are 0. With `slot_populated_i` high: bit 10 = 0, bits 9:8 = 2'b01 (indicator on), status bit 6 = 1, `link_up_o` = 1; otherwise bit 10 = 1, bits 9:8 = 2'b11, status bit 6 = 0, `link_up_o` = 0.
- R10: `slot_pwr_o` is the inverse of control bit 10.
- R11: A `dev_attach_i` pulse sets status bit 6 and `link_up_o`, and sets status bits 3 and 0 together.
- R12: An `unplug_req_i` pulse is refused (`req_reject_o` pulses, no state change) while the interlock is engaged or bits 9:8 = 2'b10 (blinking). Otherwise, with bit 10 = 1 and bits 9:8 = 2'b11 it performs an unplug as in R8, else it sets status bit 0.
- R13: Status bits 5..15 ignore writes; control bits 12..15 ignore writes and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_populated_i | input | 1 | Slot occupancy, sampled while reset is active |
| msi_en_i | input | 1 | Message interrupts enabled (pulse mode) |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 1 | Write target: 0 control, 1 status |
| cfg_wr_data | input | 16 | Write data |
| cfg_rd_sel | input | 1 | Read target: 0 control, 1 status |
| cfg_rd_data | output | 16 | Read data of the selected register |
| attn_btn_i | input | 1 | Attention button pressed (pulse) |
| dev_attach_i | input | 1 | Device plugged into the slot (pulse) |
| unplug_req_i | input | 1 | Request to remove the device (pulse) |
| intx_o | output | 1 | Level interrupt |
| msi_pulse_o | output | 1 | One-cycle message interrupt request |
| slot_pwr_o | output | 1 | Slot power enable |
| pwr_ind_o | output | 2 | Power indicator state |
| attn_ind_o | output | 2 | Attention indicator state |
| interlock_o | output | 1 | Interlock engaged |
| link_up_o | output | 1 | Data link active |
| unplug_o | output | 1 | Unplug performed (pulse) |
| req_reject_o | output | 1 | Unplug request refused (pulse) |

## Verification
Every state change, interrupt output and pulse is registered once, so each result appears at the first rising edge after the stimulus is presented, while the read port shows register contents combinationally. The bench drives inputs 1 ns after an edge, advances exactly one edge and samples 1 ns later, so a check reads the value due in that cycle; one-cycle pulses are checked again after one further edge to confirm they dropped. Register contents are read back through the read port with the select set between edges.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

    localparam int unsigned EV_N = 5;

    localparam int unsigned EV_BTN  = 0;
    localparam int unsigned EV_PFLT = 1;
    localparam int unsigned EV_MRL  = 2;
    localparam int unsigned EV_PRES = 3;
    localparam int unsigned EV_CMD  = 4;

    localparam int unsigned C_HPIE    = 5;
    localparam int unsigned C_AIND    = 6;
    localparam int unsigned C_PIND    = 8;
    localparam int unsigned C_PWROFF  = 10;
    localparam int unsigned C_LOCKTGL = 11;

    localparam int unsigned S_PRES = 6;
    localparam int unsigned S_LOCK = 7;

    typedef enum logic [1:0] {
        IND_RSVD  = 2'b00,
        IND_ON    = 2'b01,
        IND_BLINK = 2'b10,
        IND_OFF   = 2'b11
    } ind_e;

    typedef struct packed {
        logic [EV_N-1:0] ev_en;
        logic            hp_ie;
        ind_e            attn_ind;
        ind_e            pwr_ind;
        logic            pwr_off;
        logic [EV_N-1:0] ev;
        logic            present;
        logic            locked;
        logic            link_up;
        logic            unplug_pls;
        logic            reject_pls;
    } slot_st_t;

endpackage

// File: rtl/hp_w1c_guard.sv
module hp_w1c_guard #(
    parameter int unsigned N = 5
) (
    input  logic [N-1:0] old_ev,
    input  logic         wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] new_ev
);
    logic late_event;

    always_comb begin
        late_event = |(wdata & ~old_ev);
        if (!wr || late_event) begin
            new_ev = old_ev;
        end else begin
            new_ev = old_ev & ~wdata;
        end
    end
endmodule

// File: rtl/hp_irq_gen.sv
module hp_irq_gen #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         msi_en,
    input  logic         hp_ie,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] ev_en,
    output logic         intx,
    output logic         msi_pulse
);
    logic notify_d, notify_q;
    logic intx_d, intx_q;
    logic pulse_d, pulse_q;

    always_comb begin
        notify_d = hp_ie && (|(ev & ev_en));
        intx_d   = !msi_en && notify_d;
        pulse_d  = msi_en && (notify_d != notify_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            notify_q <= 1'b0;
            intx_q   <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            notify_q <= notify_d;
            intx_q   <= intx_d;
            pulse_q  <= pulse_d;
        end
    end

    assign intx      = intx_q;
    assign msi_pulse = pulse_q;
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_slot_pkg::*;
#(
    parameter int unsigned REG_W       = 16,
    parameter bit          PWR_CTRL_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_populated_i,
    input  logic             msi_en_i,
    input  logic             cfg_wr_en,
    input  logic             cfg_wr_sel,
    input  logic [REG_W-1:0] cfg_wr_data,
    input  logic             cfg_rd_sel,
    output logic [REG_W-1:0] cfg_rd_data,
    input  logic             attn_btn_i,
    input  logic             dev_attach_i,
    input  logic             unplug_req_i,
    output logic             intx_o,
    output logic             msi_pulse_o,
    output logic             slot_pwr_o,
    output logic [1:0]       pwr_ind_o,
    output logic [1:0]       attn_ind_o,
    output logic             interlock_o,
    output logic             link_up_o,
    output logic             unplug_o,
    output logic             req_reject_o
);
    localparam int unsigned CTL_USED = C_LOCKTGL + 1;

    slot_st_t         st_d, st_q, st_rst;
    logic             ctl_wr, sts_wr;
    logic [EV_N-1:0]  ev_w1c;
    logic [REG_W-1:0] ctl_vec, sts_vec;
    logic             old_off_combo, new_off_combo;
    logic             unused_hi;

    assign ctl_wr    = cfg_wr_en && !cfg_wr_sel;
    assign sts_wr    = cfg_wr_en &&  cfg_wr_sel;
    assign unused_hi = ^cfg_wr_data[REG_W-1:CTL_USED];

    hp_w1c_guard #(.N(EV_N)) u_guard (
        .old_ev (st_q.ev),
        .wr     (sts_wr),
        .wdata  (cfg_wr_data[EV_N-1:0]),
        .new_ev (ev_w1c)
    );

    // reset image, depends on slot occupancy and power-control variant
    always_comb begin
        st_rst          = '0;
        st_rst.attn_ind = IND_OFF;
        st_rst.pwr_ind  = IND_RSVD;
        st_rst.present  = slot_populated_i;
        st_rst.link_up  = slot_populated_i;
        if (PWR_CTRL_EN) begin
            st_rst.pwr_off = !slot_populated_i;
            st_rst.pwr_ind = slot_populated_i ? IND_ON : IND_OFF;
        end
    end

    always_comb begin
        st_d            = st_q;
        st_d.unplug_pls = 1'b0;
        st_d.reject_pls = 1'b0;
        st_d.ev         = ev_w1c;

        old_off_combo = st_q.pwr_off && (st_q.pwr_ind == IND_OFF);
        new_off_combo = cfg_wr_data[C_PWROFF] &&
                        (cfg_wr_data[C_PIND +: 2] == IND_OFF);

        if (ctl_wr) begin
            st_d.ev_en    = cfg_wr_data[EV_N-1:0];
            st_d.hp_ie    = cfg_wr_data[C_HPIE];
            st_d.attn_ind = ind_e'(cfg_wr_data[C_AIND +: 2]);
            st_d.pwr_ind  = ind_e'(cfg_wr_data[C_PIND +: 2]);
            st_d.pwr_off  = PWR_CTRL_EN ? cfg_wr_data[C_PWROFF] : 1'b0;
            if (cfg_wr_data[C_LOCKTGL]) begin
                st_d.locked = !st_q.locked;
            end
            if (st_q.present && new_off_combo && !old_off_combo) begin
                st_d.present     = 1'b0;
                st_d.link_up     = 1'b0;
                st_d.ev[EV_PRES] = 1'b1;
                st_d.unplug_pls  = 1'b1;
            end
        end

        if (unplug_req_i) begin
            if (st_d.locked || (st_d.pwr_ind == IND_BLINK)) begin
                st_d.reject_pls = 1'b1;
            end else if (st_d.pwr_off && (st_d.pwr_ind == IND_OFF)) begin
                st_d.present     = 1'b0;
                st_d.link_up     = 1'b0;
                st_d.ev[EV_PRES] = 1'b1;
                st_d.unplug_pls  = 1'b1;
            end else begin
                st_d.ev[EV_BTN] = 1'b1;
            end
        end

        if (dev_attach_i) begin
            st_d.present     = 1'b1;
            st_d.link_up     = 1'b1;
            st_d.ev[EV_PRES] = 1'b1;
            st_d.ev[EV_BTN]  = 1'b1;
        end

        if (attn_btn_i) begin
            st_d.ev[EV_BTN] = 1'b1;
        end

        if (ctl_wr) begin
            st_d.ev[EV_CMD] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= st_rst;
        end else begin
            st_q <= st_d;
        end
    end

    hp_irq_gen #(.N(EV_N)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .msi_en    (msi_en_i),
        .hp_ie     (st_d.hp_ie),
        .ev        (st_d.ev),
        .ev_en     (st_d.ev_en),
        .intx      (intx_o),
        .msi_pulse (msi_pulse_o)
    );

    always_comb begin
        ctl_vec                   = '0;
        ctl_vec[EV_N-1:0]         = st_q.ev_en;
        ctl_vec[C_HPIE]           = st_q.hp_ie;
        ctl_vec[C_AIND +: 2]      = st_q.attn_ind;
        ctl_vec[C_PIND +: 2]      = st_q.pwr_ind;
        ctl_vec[C_PWROFF]         = st_q.pwr_off;
        sts_vec                   = '0;
        sts_vec[EV_N-1:0]         = st_q.ev;
        sts_vec[S_PRES]           = st_q.present;
        sts_vec[S_LOCK]           = st_q.locked;
    end

    assign cfg_rd_data  = cfg_rd_sel ? sts_vec : ctl_vec;
    assign pwr_ind_o    = st_q.pwr_ind;
    assign attn_ind_o   = st_q.attn_ind;
    assign interlock_o  = st_q.locked;
    assign link_up_o    = st_q.link_up;
    assign unplug_o     = st_q.unplug_pls;
    assign req_reject_o = st_q.reject_pls;

    generate
        if (PWR_CTRL_EN) begin : g_pwr_ctl
            assign slot_pwr_o = !st_q.pwr_off;
        end else begin : g_pwr_fixed
            assign slot_pwr_o = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/hp_slot_chk.sv
module hp_slot_chk #(
    parameter int unsigned REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msi_en_i,
    input logic             cfg_wr_en,
    input logic             cfg_wr_sel,
    input logic [REG_W-1:0] cfg_wr_data,
    input logic             unplug_req_i,
    input logic             dev_attach_i,
    input logic [REG_W-1:0] sts_vec,
    input logic             intx_o,
    input logic             msi_pulse_o,
    input logic             interlock_o,
    input logic             unplug_o,
    input logic             req_reject_o
);
    // R7
    cmd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !cfg_wr_sel) |=> sts_vec[4]);

    // R6
    lock_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !cfg_wr_sel && cfg_wr_data[11]) |=> (interlock_o != $past(interlock_o)));

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr_en && !cfg_wr_sel && cfg_wr_data[11]) |=> $stable(interlock_o));

    // R12
    req_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unplug_req_i && !cfg_wr_en && interlock_o) |=> req_reject_o);

    // R12
    unplug_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(unplug_o && req_reject_o));

    // R2
    msi_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msi_pulse_o |-> $past(msi_en_i));

    // R1
    intx_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intx_o |-> !$past(msi_en_i));

    // R8
    unplug_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unplug_o && !$past(dev_attach_i)) |-> (!sts_vec[6] && sts_vec[3]));
endmodule

bind hp_slot_ctrl hp_slot_chk #(.REG_W(REG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .msi_en_i     (msi_en_i),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wr_sel   (cfg_wr_sel),
    .cfg_wr_data  (cfg_wr_data),
    .unplug_req_i (unplug_req_i),
    .dev_attach_i (dev_attach_i),
    .sts_vec      (sts_vec),
    .intx_o       (intx_o),
    .msi_pulse_o  (msi_pulse_o),
    .interlock_o  (interlock_o),
    .unplug_o     (unplug_o),
    .req_reject_o (req_reject_o)
);

// File: tb/hp_slot_ctrl_tb.sv
`timescale 1ns/1ps
module hp_slot_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_populated_i = 1'b1;
    logic        msi_en_i = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_sel = 1'b0;
    logic [15:0] cfg_wr_data = '0;
    logic        cfg_rd_sel = 1'b0;
    logic [15:0] cfg_rd_data;
    logic        attn_btn_i = 1'b0;
    logic        dev_attach_i = 1'b0;
    logic        unplug_req_i = 1'b0;
    logic        intx_o, msi_pulse_o, slot_pwr_o, interlock_o, link_up_o;
    logic        unplug_o, req_reject_o;
    logic [1:0]  pwr_ind_o, attn_ind_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    hp_slot_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .slot_populated_i(slot_populated_i),
        .msi_en_i(msi_en_i), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
        .attn_btn_i(attn_btn_i), .dev_attach_i(dev_attach_i), .unplug_req_i(unplug_req_i),
        .intx_o(intx_o), .msi_pulse_o(msi_pulse_o), .slot_pwr_o(slot_pwr_o),
        .pwr_ind_o(pwr_ind_o), .attn_ind_o(attn_ind_o), .interlock_o(interlock_o),
        .link_up_o(link_up_o), .unplug_o(unplug_o), .req_reject_o(req_reject_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [15:0] v);
        cfg_rd_sel = sel;
        #0.1;
        v = cfg_rd_data;
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        tick();
        cfg_wr_en = 1'b0; cfg_wr_data = '0;
    endtask

    task automatic pulse_attn();
        attn_btn_i = 1'b1; tick(); attn_btn_i = 1'b0;
    endtask

    task automatic pulse_req();
        unplug_req_i = 1'b1; tick(); unplug_req_i = 1'b0;
    endtask

    task automatic clr_events();
        logic [15:0] v;
        rd(1'b1, v);
        wr(1'b1, v & 16'h001F);
    endtask

    task automatic do_reset(input logic pop);
        slot_populated_i = pop;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic t_reset_pop();
        logic [15:0] v;
        do_reset(1'b1);
        rd(1'b0, v); chk("R9 ctl after reset populated", v, 16'h01C0);
        rd(1'b1, v); chk("R9 sts after reset populated", v, 16'h0040);
        chk("R9 link after reset", {15'd0, link_up_o}, 16'd1);
        chk("R10 power on after reset", {15'd0, slot_pwr_o}, 16'd1);
        chk("R1 no intx after reset", {15'd0, intx_o}, 16'd0);
        chk("R6 interlock after reset", {15'd0, interlock_o}, 16'd0);
    endtask

    task automatic t_cmd_done();
        logic [15:0] v;
        wr(1'b0, 16'h01C0);
        rd(1'b1, v); chk("R7 command done set", v, 16'h0050);
        wr(1'b1, 16'h0010);
        rd(1'b1, v); chk("R4 command done cleared", v, 16'h0040);
    endtask

    task automatic t_intx();
        logic [15:0] v;
        msi_en_i = 1'b0;
        wr(1'b0, 16'h01E1);
        chk("R1 disabled event gives no intx", {15'd0, intx_o}, 16'd0);
        pulse_attn();
        rd(1'b1, v); chk("R4 button latched", v, 16'h0051);
        chk("R1 intx raised", {15'd0, intx_o}, 16'd1);
        chk("R1 no msi in level mode", {15'd0, msi_pulse_o}, 16'd0);
        wr(1'b1, 16'h0011);
        rd(1'b1, v); chk("R4 both events cleared", v, 16'h0040);
        chk("R1 intx dropped", {15'd0, intx_o}, 16'd0);
    endtask

    task automatic t_msi();
        logic [15:0] v;
        msi_en_i = 1'b1;
        pulse_attn();
        chk("R2 msi pulse on rise", {15'd0, msi_pulse_o}, 16'd1);
        chk("R2 intx low in msi mode", {15'd0, intx_o}, 16'd0);
        tick();
        chk("R2 pulse lasts one cycle", {15'd0, msi_pulse_o}, 16'd0);
        pulse_attn();
        chk("R3 no pulse on repeated event", {15'd0, msi_pulse_o}, 16'd0);
        rd(1'b1, v); chk("R3 status unchanged", v, 16'h0041);
        wr(1'b1, 16'h0001);
        chk("R2 msi pulse on fall", {15'd0, msi_pulse_o}, 16'd1);
        tick();
        chk("R2 fall pulse one cycle", {15'd0, msi_pulse_o}, 16'd0);
    endtask

    task automatic t_race();
        logic [15:0] v;
        pulse_attn();
        wr(1'b1, 16'h0011);
        rd(1'b1, v); chk("R5 clear cancelled", v, 16'h0041);
        wr(1'b1, 16'h0001);
        rd(1'b1, v); chk("R5 matching clear works", v, 16'h0040);
    endtask

    task automatic t_lock();
        logic [15:0] v;
        wr(1'b0, 16'h09E1);
        chk("R6 interlock engaged", {15'd0, interlock_o}, 16'd1);
        rd(1'b1, v); chk("R6 interlock status bit", v, 16'h00D0);
        rd(1'b0, v); chk("R6 toggle bit reads 0", v, 16'h01E1);
    endtask

    task automatic t_reject();
        logic [15:0] v;
        pulse_req();
        chk("R12 refused while locked", {15'd0, req_reject_o}, 16'd1);
        chk("R12 no unplug while locked", {15'd0, unplug_o}, 16'd0);
        rd(1'b1, v); chk("R12 status untouched", v, 16'h00D0);
        wr(1'b0, 16'h09E1);
        chk("R6 interlock released", {15'd0, interlock_o}, 16'd0);
        wr(1'b0, 16'h02E1);
        pulse_req();
        chk("R12 refused while blinking", {15'd0, req_reject_o}, 16'd1);
        tick();
        chk("R12 refuse pulse one cycle", {15'd0, req_reject_o}, 16'd0);
    endtask

    task automatic t_req_button();
        logic [15:0] v;
        wr(1'b0, 16'h01E1);
        clr_events();
        pulse_req();
        chk("R12 accepted request not refused", {15'd0, req_reject_o}, 16'd0);
        chk("R12 powered slot not unplugged", {15'd0, unplug_o}, 16'd0);
        rd(1'b1, v); chk("R12 request raises button", v, 16'h0041);
        clr_events();
    endtask

    task automatic t_unplug();
        logic [15:0] v;
        wr(1'b0, 16'h07E1);
        chk("R8 unplug pulse", {15'd0, unplug_o}, 16'd1);
        rd(1'b1, v); chk("R8 presence cleared change set", v, 16'h0018);
        chk("R8 link down", {15'd0, link_up_o}, 16'd0);
        chk("R10 power off", {15'd0, slot_pwr_o}, 16'd0);
        tick();
        chk("R8 unplug pulse one cycle", {15'd0, unplug_o}, 16'd0);
    endtask

    task automatic t_attach();
        logic [15:0] v;
        dev_attach_i = 1'b1; tick(); dev_attach_i = 1'b0;
        rd(1'b1, v); chk("R11 attach status", v, 16'h0059);
        chk("R11 link up", {15'd0, link_up_o}, 16'd1);
    endtask

    task automatic t_no_repeat_unplug();
        logic [15:0] v;
        wr(1'b0, 16'h07E1);
        chk("R8 no unplug when already off", {15'd0, unplug_o}, 16'd0);
        rd(1'b1, v); chk("R8 presence kept", v, 16'h0059);
    endtask

    task automatic t_req_unplug();
        logic [15:0] v;
        pulse_req();
        chk("R12 request unplugs", {15'd0, unplug_o}, 16'd1);
        chk("R12 request not refused", {15'd0, req_reject_o}, 16'd0);
        rd(1'b1, v); chk("R12 presence cleared", v, 16'h0019);
    endtask

    task automatic t_readonly();
        logic [15:0] v;
        clr_events();
        rd(1'b1, v); chk("R4 all events cleared", v, 16'h0000);
        wr(1'b1, 16'hFFE0);
        rd(1'b1, v); chk("R13 status upper bits ignore writes", v, 16'h0000);
        wr(1'b0, 16'hF7E1);
        rd(1'b0, v); chk("R13 control upper bits read 0", v, 16'h07E1);
        chk("R13 interlock untouched", {15'd0, interlock_o}, 16'd0);
    endtask

    task automatic t_reset_empty();
        logic [15:0] v;
        do_reset(1'b0);
        rd(1'b0, v); chk("R9 ctl after reset empty", v, 16'h07C0);
        rd(1'b1, v); chk("R9 sts after reset empty", v, 16'h0000);
        chk("R10 power off when empty", {15'd0, slot_pwr_o}, 16'd0);
        chk("R9 link down when empty", {15'd0, link_up_o}, 16'd0);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick();
        t_reset_pop();
        t_cmd_done();
        t_intx();
        t_msi();
        t_race();
        t_lock();
        t_reject();
        t_req_button();
        t_unplug();
        t_attach();
        t_no_repeat_unplug();
        t_req_unplug();
        t_readonly();
        t_reset_empty();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule